// File: doc/BRIEF.md
# UART Interrupt and Receive Status Unit

This unit sits beside a serial port's transmit and receive datapath. It gathers four interrupt causes into one register: a character arriving, a receive timeout, space opening in the transmit FIFO, and a change on the clear-to-send input. Each cause is held as a sticky status bit and gated by an enable bit in the same register. The gated bits are ORed into one interrupt line. Software writes the register to load both fields. A separate clear strobe removes only the bits written as one.

The unit also keeps a receive status word. It holds sticky per-character error flags, the current clear-to-send level and a mirror of the receive FIFO empty indication. Software acknowledges errors by writing the flags it has seen back to the status strobe. The receiver, the transmitter and a bit-rate tick generator supply single-cycle event pulses. The raw clear-to-send pin is synchronised inside the unit.

Top module: `uart_irq_status`

## Requirements
- R1: After reset the interrupt register reads zero, the interrupt line is low, and the status word holds only the receive-empty mirror and the clear-to-send level, both taken from their inputs.
- R2: In the interrupt register the enables sit at bit 22 (timeout), bit 21 (transmit), bit 20 (receive) and bit 17 (clear-to-send change). The matching sticky bits sit at 6, 5, 4 and 1. A plain write loads all eight bits from the write data, and every other bit reads zero.
- R3: A clear-strobe write zeroes each enable or sticky bit whose write-data bit is one and leaves every other bit unchanged.
- R4: The interrupt line is high exactly when at least one sticky bit and its own enable are both one.
- R5: A receive push pulse sets bit 4 and a transmit-space pulse sets bit 5. An event arriving in the same cycle as a clear or a plain write of that bit leaves the bit set.
- R6: Bit 6 sets on the 32nd bit tick counted while the receive FIFO is not empty with no push since counting began. A push restarts the count at zero. While the FIFO is empty the count stays at zero, and it does not fire again until it restarts.
- R7: The synchronised clear-to-send level appears at status bit 28 two clock edges after the pin changes. Bit 1 of the interrupt register sets on the third edge, for rising and falling changes alike.
- R8: On a receive push the error flags record break at bit 18 in preference to parity at bit 17, and parity in preference to framing at bit 16. An overrun pulse sets bit 19 whatever the other flags are.
- R9: The error flags are sticky across characters. A status write clears the flags in bits 19..16 written as one, and an error event in the same cycle keeps its flag set.
- R10: Status bit 24 follows the receive-empty input one edge later, and status bits other than 28, 24 and 19..16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wdata_i | input | 32 | Write data shared by the three write strobes |
| intr_wr_i | input | 1 | Plain write of the interrupt register |
| intr_clr_i | input | 1 | Clear-strobe write of the interrupt register |
| stat_wr_i | input | 1 | Write-back of the status word that clears error flags |
| rx_push_i | input | 1 | Pulse: a character entered the receive FIFO |
| rx_brk_i | input | 1 | Break seen on the pushed character |
| rx_par_i | input | 1 | Parity error on the pushed character |
| rx_frm_i | input | 1 | Framing error on the pushed character |
| rx_ovr_i | input | 1 | Pulse: receive overrun |
| rx_empty_i | input | 1 | Receive FIFO empty level |
| tx_space_i | input | 1 | Pulse: transmit FIFO has room |
| bit_tick_i | input | 1 | Pulse once per serial bit period |
| cts_pin_i | input | 1 | Asynchronous clear-to-send pin |
| intr_rdata_o | output | 32 | Interrupt register view |
| stat_rdata_o | output | 32 | Status word view |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can fall in the same cycle: a hardware event setting a bit and software clearing that bit. This can happen with the clear strobe against a transmit-space pulse, and with a status write-back against a pushed break. The bench drives both on the same clock edge and reads the register one edge later. A correct unit shows the colliding bit still set and the other bits named in the write cleared. The enable/sticky interaction is swept over all 256 combinations, and each interrupt value is compared with an OR computed in the bench.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // source index order inside the unit: 0 cts change, 1 rx, 2 tx, 3 rx timeout
  localparam int NSRC = 4;

  localparam int OVR_BIT  = 19;
  localparam int BRK_BIT  = 18;
  localparam int PAR_BIT  = 17;
  localparam int FRM_BIT  = 16;
  localparam int EMPTY_BIT = 24;
  localparam int CTSLVL_BIT = 28;

  function automatic int en_pos(input int idx);
    case (idx)
      0:       return 17;
      1:       return 20;
      2:       return 21;
      default: return 22;
    endcase
  endfunction

  function automatic int st_pos(input int idx);
    case (idx)
      0:       return 1;
      1:       return 4;
      2:       return 5;
      default: return 6;
    endcase
  endfunction

  // pick the enable field out of a bus word
  function automatic logic [NSRC-1:0] en_field(input logic [31:0] w);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = w[en_pos(i)];
    return r;
  endfunction

  function automatic logic [NSRC-1:0] st_field(input logic [31:0] w);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++) r[i] = w[st_pos(i)];
    return r;
  endfunction

  function automatic logic [31:0] intr_view(input logic [NSRC-1:0] en,
                                            input logic [NSRC-1:0] st);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < NSRC; i++) begin
      v[en_pos(i)] = en[i];
      v[st_pos(i)] = st[i];
    end
    return v;
  endfunction

  function automatic logic pending(input logic [NSRC-1:0] en,
                                   input logic [NSRC-1:0] st);
    return |(en & st);
  endfunction

  // one-hot0 {brk,par,frm}: break outranks parity, parity outranks framing
  function automatic logic [2:0] rank_err(input logic brk, input logic par,
                                          input logic frm);
    if (brk)      return 3'b100;
    else if (par) return 3'b010;
    else if (frm) return 3'b001;
    else          return 3'b000;
  endfunction

  // flags ordered {ovr,brk,par,frm}
  function automatic logic [3:0] flags_next(input logic [3:0] cur,
                                            input logic [3:0] clr,
                                            input logic [3:0] set);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [31:0] stat_view(input logic cts_lvl,
                                            input logic empty,
                                            input logic [3:0] flags);
    logic [31:0] v;
    v = '0;
    v[CTSLVL_BIT] = cts_lvl;
    v[EMPTY_BIT]  = empty;
    v[OVR_BIT:FRM_BIT] = flags;
    return v;
  endfunction

endpackage

// File: rtl/uart_irq_cts_sync.sv
module uart_irq_cts_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic lvl_o,
  output logic chg_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign lvl_o = sync_q[STAGES-1];
  assign chg_o = sync_q[STAGES-1] ^ last_q;

  // R7
  cts_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |=> (last_q == $past(lvl_o)));

endmodule

// File: rtl/uart_irq_rx_timeout.sv
module uart_irq_rx_timeout #(
  parameter int TO_BITS = 32,
  localparam int CNT_W  = $clog2(TO_BITS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_tick_i,
  input  logic push_i,
  input  logic empty_i,
  output logic fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             restart;
  logic             counting;

  assign restart  = push_i | empty_i;
  assign counting = bit_tick_i & (cnt_q < CNT_W'(TO_BITS));
  assign fire_o   = bit_tick_i & ~restart & (cnt_q == CNT_W'(TO_BITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (counting) cnt_q <= cnt_q + 1'b1;
  end

  // R6
  to_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(TO_BITS));

  // R6
  to_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  // R6
  to_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> (cnt_q == '0));

endmodule

// File: rtl/uart_irq_err_flags.sv
module uart_irq_err_flags
  import uart_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       push_i,
  input  logic       brk_i,
  input  logic       par_i,
  input  logic       frm_i,
  input  logic       ovr_i,
  input  logic       clr_i,
  input  logic [3:0] clr_mask_i,
  output logic [3:0] flags_o
);
  logic [3:0] flags_q;
  logic [3:0] set_vec;
  logic [3:0] clr_vec;

  assign set_vec = {ovr_i, push_i ? rank_err(brk_i, par_i, frm_i) : 3'b000};
  assign clr_vec = clr_i ? clr_mask_i : 4'b0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_next(flags_q, clr_vec, set_vec);
  end

  assign flags_o = flags_q;

  // R8
  brk_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && brk_i && !flags_q[1] && !flags_q[0]) |=> (flags_q[2] && !flags_q[1] && !flags_q[0]));

  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_i |=> flags_q[3]);

  // R9
  ovr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && clr_mask_i[3] && !ovr_i) |=> !flags_q[3]);

endmodule

// File: rtl/uart_irq_bank.sv
module uart_irq_bank
  import uart_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic            clr_i,
  input  logic [NSRC-1:0] wr_en_i,
  input  logic [NSRC-1:0] wr_st_i,
  input  logic [NSRC-1:0] evt_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] st_o,
  output logic            irq_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic en_q, st_q;
    logic en_d, st_d;

    always_comb begin
      en_d = en_q;
      st_d = st_q;
      if (wr_i) begin
        en_d = wr_en_i[i];
        st_d = wr_st_i[i];
      end
      if (clr_i) begin
        if (wr_en_i[i]) en_d = 1'b0;
        if (wr_st_i[i]) st_d = 1'b0;
      end
      if (evt_i[i]) st_d = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q <= 1'b0;
        st_q <= 1'b0;
      end else begin
        en_q <= en_d;
        st_q <= st_d;
      end
    end

    assign en_o[i] = en_q;
    assign st_o[i] = st_q;

    // R5
    evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[i] |=> st_q);

    // R3
    clr_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && wr_st_i[i] && !evt_i[i]) |=> !st_q);

    // R3
    clr_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && wr_en_i[i]) |=> !en_q);
  end

  assign irq_o = pending(en_o, st_o);

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int TO_BITS    = 32,
  parameter int CTS_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] wdata_i,
  input  logic        intr_wr_i,
  input  logic        intr_clr_i,
  input  logic        stat_wr_i,
  input  logic        rx_push_i,
  input  logic        rx_brk_i,
  input  logic        rx_par_i,
  input  logic        rx_frm_i,
  input  logic        rx_ovr_i,
  input  logic        rx_empty_i,
  input  logic        tx_space_i,
  input  logic        bit_tick_i,
  input  logic        cts_pin_i,
  output logic [31:0] intr_rdata_o,
  output logic [31:0] stat_rdata_o,
  output logic        irq_o
);
  logic            cts_lvl;
  logic            cts_chg;
  logic            rto_fire;
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] en_vec;
  logic [NSRC-1:0] st_vec;
  logic [3:0]      err_flags;
  logic            empty_q;
  logic            unused_wdata;

  assign unused_wdata = ^{wdata_i[31:23], wdata_i[15:7], wdata_i[3:2], wdata_i[0]};

  uart_irq_cts_sync #(.STAGES(CTS_STAGES)) u_cts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cts_pin_i),
    .lvl_o  (cts_lvl),
    .chg_o  (cts_chg)
  );

  uart_irq_rx_timeout #(.TO_BITS(TO_BITS)) u_rto (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_tick_i (bit_tick_i),
    .push_i     (rx_push_i),
    .empty_i    (rx_empty_i),
    .fire_o     (rto_fire)
  );

  assign evt_vec = {rto_fire, tx_space_i, rx_push_i, cts_chg};

  uart_irq_bank u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (intr_wr_i),
    .clr_i   (intr_clr_i),
    .wr_en_i (en_field(wdata_i)),
    .wr_st_i (st_field(wdata_i)),
    .evt_i   (evt_vec),
    .en_o    (en_vec),
    .st_o    (st_vec),
    .irq_o   (irq_o)
  );

  uart_irq_err_flags u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (rx_push_i),
    .brk_i      (rx_brk_i),
    .par_i      (rx_par_i),
    .frm_i      (rx_frm_i),
    .ovr_i      (rx_ovr_i),
    .clr_i      (stat_wr_i),
    .clr_mask_i (wdata_i[OVR_BIT:FRM_BIT]),
    .flags_o    (err_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) empty_q <= 1'b1;
    else         empty_q <= rx_empty_i;
  end

  assign intr_rdata_o = intr_view(en_vec, st_vec);
  assign stat_rdata_o = stat_view(cts_lvl, empty_q, err_flags);

  // R7
  cts_to_intr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cts_chg |=> intr_rdata_o[1]);

  // R6
  rto_to_intr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rto_fire |=> intr_rdata_o[6]);

  // R4
  irq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_rdata_o[6:0] == 7'd0) |-> !irq_o);

endmodule

// File: tb/uart_irq_status_tb_top.sv
module uart_irq_status_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] wdata = '0;
  logic        intr_wr = 0, intr_clr = 0, stat_wr = 0;
  logic        rx_push = 0, rx_brk = 0, rx_par = 0, rx_frm = 0, rx_ovr = 0;
  logic        rx_empty = 1, tx_space = 0, bit_tick = 0, cts_pin = 0;
  logic [31:0] intr_rd, stat_rd;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_irq_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wdata_i(wdata),
    .intr_wr_i(intr_wr), .intr_clr_i(intr_clr), .stat_wr_i(stat_wr),
    .rx_push_i(rx_push), .rx_brk_i(rx_brk), .rx_par_i(rx_par), .rx_frm_i(rx_frm),
    .rx_ovr_i(rx_ovr), .rx_empty_i(rx_empty), .tx_space_i(tx_space),
    .bit_tick_i(bit_tick), .cts_pin_i(cts_pin),
    .intr_rdata_o(intr_rd), .stat_rdata_o(stat_rd), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_intr(input logic [3:0] en, input logic [3:0] st);
    return (32'(en[0]) << 17) | (32'(en[1]) << 20) | (32'(en[2]) << 21) | (32'(en[3]) << 22)
         | (32'(st[0]) << 1)  | (32'(st[1]) << 4)  | (32'(st[2]) << 5)  | (32'(st[3]) << 6);
  endfunction

  task automatic intr_clear_all();
    wdata = 32'hFFFF_FFFF; intr_clr = 1; step(); intr_clr = 0; wdata = '0;
  endtask

  task automatic stat_clear_all();
    wdata = 32'h000F_0000; stat_wr = 1; step(); stat_wr = 0; wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      bit_tick = 1; step(); bit_tick = 0; step();
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    // R1
    chk("R1 intr", intr_rd, 32'h0);
    chk("R1 stat", stat_rd, 32'h0100_0000);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R2 all ones write
    wdata = 32'hFFFF_FFFF; intr_wr = 1; step(); intr_wr = 0;
    chk("R2 layout", intr_rd, 32'h0072_0072);
    // R3 selective clear
    wdata = 32'h0020_0010; intr_clr = 1; step(); intr_clr = 0;
    chk("R3 selective clear", intr_rd, 32'h0052_0062);

    // R4 / R2 sweep of every enable/sticky pair
    for (int e = 0; e < 16; e++) begin
      for (int s = 0; s < 16; s++) begin
        wdata = exp_intr(4'(e), 4'(s)); intr_wr = 1; step(); intr_wr = 0;
        chk("R2 sweep", intr_rd, exp_intr(4'(e), 4'(s)));
        chk("R4 irq", {31'd0, irq}, {31'd0, |(4'(e) & 4'(s))});
      end
    end

    // R5 events set their bits
    intr_clear_all();
    rx_push = 1; step(); rx_push = 0;
    chk("R5 rx", intr_rd, 32'h0000_0010);
    tx_space = 1; step(); tx_space = 0;
    chk("R5 tx", intr_rd, 32'h0000_0030);
    // R5 collision: clear of bits 4,5 with a tx event in the same cycle
    wdata = 32'h0000_0030; intr_clr = 1; tx_space = 1; step(); intr_clr = 0; tx_space = 0;
    chk("R5 event beats clear", intr_rd, 32'h0000_0020);
    // R5 collision: plain write of zero with an rx event
    wdata = 32'h0; intr_wr = 1; rx_push = 1; step(); intr_wr = 0; rx_push = 0;
    chk("R5 event beats write", intr_rd, 32'h0000_0010);
    intr_clear_all();

    // R6 receive timeout
    rx_empty = 0; rx_push = 1; step(); rx_push = 0;
    intr_clear_all();
    ticks(31);
    chk("R6 31 ticks", {31'd0, intr_rd[6]}, 32'd0);
    ticks(1);
    chk("R6 32 ticks", {31'd0, intr_rd[6]}, 32'd1);
    intr_clear_all();
    ticks(10);
    chk("R6 one shot", {31'd0, intr_rd[6]}, 32'd0);
    rx_push = 1; step(); rx_push = 0;
    ticks(20);
    rx_push = 1; step(); rx_push = 0;
    ticks(31);
    chk("R6 push restarts", {31'd0, intr_rd[6]}, 32'd0);
    ticks(1);
    chk("R6 after restart", {31'd0, intr_rd[6]}, 32'd1);
    intr_clear_all();
    rx_empty = 1; step();
    ticks(40);
    chk("R6 empty holds", {31'd0, intr_rd[6]}, 32'd0);
    // R10 empty mirror
    stat_clear_all();
    chk("R10 empty high", stat_rd, 32'h0100_0000);
    rx_empty = 0; step();
    chk("R10 empty low", stat_rd, 32'h0);
    rx_empty = 1; step();

    // R7 clear-to-send rising then falling
    intr_clear_all();
    cts_pin = 1; step();
    chk("R7 level edge1", {31'd0, stat_rd[28]}, 32'd0);
    step();
    chk("R7 level edge2", {31'd0, stat_rd[28]}, 32'd1);
    chk("R7 no change yet", {31'd0, intr_rd[1]}, 32'd0);
    step();
    chk("R7 rise change", {31'd0, intr_rd[1]}, 32'd1);
    intr_clear_all();
    cts_pin = 0; step(); step();
    chk("R7 fall level", {31'd0, stat_rd[28]}, 32'd0);
    step();
    chk("R7 fall change", {31'd0, intr_rd[1]}, 32'd1);
    intr_clear_all();

    // R8 every combination of {ovr,brk,par,frm}
    for (int v = 0; v < 16; v++) begin
      logic [31:0] exp;
      stat_clear_all();
      rx_ovr = v[3]; rx_brk = v[2]; rx_par = v[1]; rx_frm = v[0]; rx_push = 1;
      step();
      rx_ovr = 0; rx_brk = 0; rx_par = 0; rx_frm = 0; rx_push = 0;
      exp = 32'(v[3]) << 19;
      if (v[2])      exp |= 32'h0004_0000;
      else if (v[1]) exp |= 32'h0002_0000;
      else if (v[0]) exp |= 32'h0001_0000;
      chk("R8 priority", stat_rd & 32'h000F_0000, exp);
    end

    // R9 sticky then selective clear and collision
    stat_clear_all();
    rx_par = 1; rx_push = 1; step(); rx_par = 0;
    rx_frm = 1; step(); rx_frm = 0; rx_push = 0;
    chk("R9 sticky", stat_rd & 32'h000F_0000, 32'h0003_0000);
    wdata = 32'h0002_0000; stat_wr = 1; step(); stat_wr = 0;
    chk("R9 selective", stat_rd & 32'h000F_0000, 32'h0001_0000);
    wdata = 32'h000F_0000; stat_wr = 1; rx_push = 1; rx_brk = 1; step();
    stat_wr = 0; rx_push = 0; rx_brk = 0;
    chk("R9 event beats clear", stat_rd & 32'h000F_0000, 32'h0004_0000);
    // R10 unused bits
    chk("R10 other bits", stat_rd & ~32'h110F_0000, 32'h0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule